// File: doc/BRIEF.md
# Serial Character Transmitter with Modem Flow Control

This block serializes characters for one asynchronous serial channel. A host writes a character into a one-deep holding register while `tx_rdy` is high. On a later tick of the baud enable the character moves into the shift register and leaves on `txd`: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, then a high stop period. In the normal mode the baud enable runs at sixteen times the bit rate, so the stop period can be set in sixteenths of a bit. In the one-times mode every enable is one whole bit.

Two handshakes sit around the serializer. An active-low clear-to-send input can hold back the start of each character. A request-to-send output is set and cleared by host strobes. When auto mode is on, the output also drops by itself one bit time after a pending disable has drained every held character. A disable issued while characters are still held only becomes pending, so the characters already written are still sent. `tx_rdy` together with `tx_emt` marks an underrun: the holding register and the shifter are both empty.

Top module: `uart_tx_fc`

## Requirements
- R1: Directly after reset `txd` is 1, `rts` is 0, `tx_rdy` is 0 and `tx_emt` is 1.
- R2: One cycle after a `tx_enable` strobe, `tx_rdy` and `tx_emt` are both 1 (underrun). A `wr` is taken only while `tx_rdy` is 1. A write made while `tx_rdy` is 0 is ignored.
- R3: In 16x mode a frame is a 16-tick low start bit, then `char_len`+5 data bits (codes 0..3 give 5..8) LSB first at 16 ticks each, then, if `par_en` is 1, a 16-tick parity bit. Parity makes the count of ones over the data and the parity bit even when `par_odd` is 0, and odd when it is 1.
- R4: In 16x mode the stop period for code n in `stop_code` lasts 17+n ticks for 5-bit characters. For 6 to 8-bit characters it lasts 9+n ticks when n is 0..7 and 17+n ticks when n is 8..15.
- R5: When `x1_mode` is 1, every bit lasts one tick. The stop period is 1 tick when `stop_code[3]` is 0 and 2 ticks when it is 1.
- R6: A character that is already held when a stop period ends starts on the very tick that ends it, with no idle tick between frames.
- R7: When `cts_gate` is 1, a character starts only while `cts_n` is 0. Until then `txd` stays 1 and the character stays held (`tx_emt` 0).
- R8: A change of `cts_n` during a frame does not alter that frame. When `cts_gate` is 0, `cts_n` has no effect.
- R9: A `tx_disable` while data is held or shifting makes the disable pending. `tx_rdy` drops at once, every held character is still sent, and the transmitter is disabled once it has drained.
- R10: When `auto_rts` is 1 and a pending disable drains, `rts` falls on the 16th tick (in `x1_mode`, the 1st tick) after the tick that ends the last stop period.
- R11: When auto negation does not apply, `rts` changes only through `rts_set` (to 1) and `rts_clr` (to 0), with set taking priority. A disable issued during underrun takes effect at once and leaves `rts` unchanged.
- R12: `txd` changes only in cycles in which `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Baud enable, one pulse per sub-bit (16x) or per bit (1x) |
| x1_mode | input | 1 | 1: each tick is a whole bit |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_code | input | 4 | Stop length code |
| cts_gate | input | 1 | Gate character starts on `cts_n` |
| cts_n | input | 1 | Clear to send, active low |
| auto_rts | input | 1 | Drop `rts` after a pending disable drains |
| tx_enable | input | 1 | Enable strobe |
| tx_disable | input | 1 | Disable strobe |
| rts_set | input | 1 | Strobe: set `rts` |
| rts_clr | input | 1 | Strobe: clear `rts` |
| wr | input | 1 | Write holding register |
| wdata | input | 8 | Character to write |
| txd | output | 1 | Serial data, idle high |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emt | output | 1 | Holding register and shifter both empty |
| rts | output | 1 | Request to send, 1 = asserted |

## Verification
The block has no parameters, so the bench builds it as it is and reaches the variants through its mode inputs instead. With the tick running every fourth clock, the bench sets every character length, both parities and stop codes at both ends of each range. The 16x sequence can therefore be compared tick for tick, and the one-times mode shrinks each bit to one tick. Joining several characters into one expected stream exposes any idle tick between frames. The drain sequence is measured from the moment `tx_emt` rises, which pins down the exact tick on which `rts` drops.

// File: rtl/uart_tx_fc.sv
module uart_tx_fc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       x1_mode,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [3:0] stop_code,
  input  logic       cts_gate,
  input  logic       cts_n,
  input  logic       auto_rts,
  input  logic       tx_enable,
  input  logic       tx_disable,
  input  logic       rts_set,
  input  logic       rts_clr,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_emt,
  output logic       rts
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;

  logic       en_q, dis_pend, hold_full, par_q, rts_wait;
  logic [7:0] hold, shreg;
  logic [5:0] cnt, stop_m1;
  logic [2:0] bidx;
  logic [4:0] rts_cnt;

  logic [2:0] last_idx;
  logic [5:0] bit_m1;
  logic [7:0] len_mask;
  logic       can_go, drained;

  assign last_idx = {1'b1, char_len};
  assign bit_m1   = x1_mode ? 6'd0 : 6'd15;
  assign len_mask = 8'hFF >> (2'd3 - char_len);
  assign can_go   = hold_full && en_q && (!cts_gate || !cts_n);
  assign drained  = (st == S_IDLE) && !hold_full;

  assign tx_rdy = en_q && !dis_pend && !hold_full;
  assign tx_emt = drained;

  always_comb begin
    if (x1_mode)             stop_m1 = {5'd0, stop_code[3]};
    else if (char_len == 0)  stop_m1 = 6'd16 + {2'd0, stop_code};
    else if (!stop_code[3])  stop_m1 = 6'd8 + {2'd0, stop_code};
    else                     stop_m1 = 6'd16 + {2'd0, stop_code};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; txd <= 1'b1; cnt <= '0; bidx <= '0;
      shreg <= '0; hold <= '0; hold_full <= 1'b0; par_q <= 1'b0;
    end else begin
      if (wr && tx_rdy) begin
        hold <= wdata;
        hold_full <= 1'b1;
      end
      if (tick) begin
        if (st != S_IDLE && cnt != 0) begin
          cnt <= cnt - 6'd1;
        end else begin
          case (st)
            S_START: begin
              st <= S_DATA; bidx <= '0; txd <= shreg[0]; cnt <= bit_m1;
            end
            S_DATA: begin
              if (bidx != last_idx) begin
                bidx <= bidx + 3'd1; txd <= shreg[1];
                shreg <= shreg >> 1; cnt <= bit_m1;
              end else if (par_en) begin
                st <= S_PAR; txd <= par_q; cnt <= bit_m1;
              end else begin
                st <= S_STOP; txd <= 1'b1; cnt <= stop_m1;
              end
            end
            S_PAR: begin
              st <= S_STOP; txd <= 1'b1; cnt <= stop_m1;
            end
            default: begin
              if (can_go) begin
                st <= S_START; txd <= 1'b0; cnt <= bit_m1;
                shreg <= hold; hold_full <= 1'b0;
                par_q <= (^(hold & len_mask)) ^ par_odd;
              end else begin
                st <= S_IDLE; txd <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; dis_pend <= 1'b0; rts <= 1'b0;
      rts_wait <= 1'b0; rts_cnt <= '0;
    end else begin
      if (tx_enable) begin
        en_q <= 1'b1; dis_pend <= 1'b0;
      end else if (tx_disable && en_q && !dis_pend) begin
        if (drained) en_q <= 1'b0;
        else         dis_pend <= 1'b1;
      end else if (dis_pend && drained) begin
        en_q <= 1'b0; dis_pend <= 1'b0;
        if (auto_rts) begin
          rts_wait <= 1'b1;
          rts_cnt  <= bit_m1[4:0] + 5'd1;
        end
      end

      if (rts_set) begin
        rts <= 1'b1; rts_wait <= 1'b0;
      end else if (rts_clr) begin
        rts <= 1'b0; rts_wait <= 1'b0;
      end else if (rts_wait && tick) begin
        if (rts_cnt == 5'd1) begin
          rts <= 1'b0; rts_wait <= 1'b0;
        end
        rts_cnt <= rts_cnt - 5'd1;
      end
    end
  end
endmodule

module uart_tx_fc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       txd,
  input logic       tx_rdy,
  input logic       tx_emt,
  input logic       rts,
  input logic       rts_set,
  input logic       rts_clr,
  input logic       auto_rts,
  input logic       cts_gate,
  input logic       cts_n,
  input logic       wr,
  input logic       dis_pend,
  input logic [2:0] st
);
  a_r12_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  a_r2_underrun_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rdy && tx_emt) |-> txd);

  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && tx_rdy) |=> !tx_emt);

  a_r11_rts_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> $past(rts_set));

  a_r11_manual_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rts) && !$past(auto_rts)) |-> $past(rts_clr));

  a_r7_cts_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && $past(st) != 3'd1) |-> $past(!cts_gate || !cts_n));

  a_r9_pending_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dis_pend |-> !tx_rdy);
endmodule

bind uart_tx_fc uart_tx_fc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .tx_rdy(tx_rdy),
  .tx_emt(tx_emt), .rts(rts), .rts_set(rts_set), .rts_clr(rts_clr),
  .auto_rts(auto_rts), .cts_gate(cts_gate), .cts_n(cts_n), .wr(wr),
  .dis_pend(dis_pend), .st(st)
);

// File: tb/sim_uart_tx_fc.sv
module sim_uart_tx_fc;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic x1_mode = 0, par_en = 0, par_odd = 0, cts_gate = 0, cts_n = 1, auto_rts = 0;
  logic [1:0] char_len = 2'd3;
  logic [3:0] stop_code = 4'd0;
  logic tx_enable = 0, tx_disable = 0, rts_set = 0, rts_clr = 0, wr = 0;
  logic [7:0] wdata = 8'h00;
  logic txd, tx_rdy, tx_emt, rts;

  int nchk = 0, nerr = 0, rem = 0, phase = 0;
  int exp_q[$];
  int len_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  uart_tx_fc u0 (.*);

  always @(negedge clk) begin
    tick  <= (phase == 3);
    phase <= (phase + 1) % 4;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  function automatic int stop_ticks(input logic x1, input logic [1:0] len, input logic [3:0] c);
    if (x1) return c[3] ? 2 : 1;
    if (len == 2'd0) return 17 + int'(c);
    return c[3] ? 17 + int'(c) : 9 + int'(c);
  endfunction

  task automatic expect_frame(input logic [7:0] d, input bit join_prev, input string tag);
    int nb, bt, sb, ones, tot;
    nb = int'(char_len) + 5;
    bt = x1_mode ? 1 : 16;
    sb = stop_ticks(x1_mode, char_len, stop_code);
    ones = 0; tot = 0;
    for (int i = 0; i < bt; i++) begin exp_q.push_back(0); tot++; end
    for (int b = 0; b < nb; b++) begin
      if (d[b]) ones++;
      for (int i = 0; i < bt; i++) begin exp_q.push_back(int'(d[b])); tot++; end
    end
    if (par_en) begin
      for (int i = 0; i < bt; i++) begin
        exp_q.push_back(par_odd ? ((ones + 1) % 2) : (ones % 2)); tot++;
      end
    end
    for (int i = 0; i < sb; i++) begin exp_q.push_back(1); tot++; end
    if (join_prev && len_q.size() > 0) len_q[len_q.size()-1] += tot;
    else begin len_q.push_back(tot); tag_q.push_back(tag); end
  endtask

  initial begin
    int fr_err, fr_idx, bad_idx, bad_act, bad_exp, e;
    string tg;
    fr_err = 0; fr_idx = 0; bad_idx = 0; bad_act = 0; bad_exp = 0; tg = "";
    forever begin
      @(posedge clk);
      if (tick && rst_n) begin
        @(negedge clk);
        if (rem == 0 && txd == 1'b0) begin
          if (len_q.size() == 0) begin
            chk(0, "R2", "start bit with no character written (txd)", 0, 1);
          end else begin
            rem = len_q.pop_front(); tg = tag_q.pop_front();
            fr_err = 0; fr_idx = 0;
          end
        end
        if (rem > 0) begin
          e = exp_q.pop_front();
          if (e != int'(txd) && fr_err == 0) begin
            fr_err = 1; bad_idx = fr_idx; bad_act = int'(txd); bad_exp = e;
          end
          fr_idx++; rem--;
          if (rem == 0) begin
            nchk++;
            if (fr_err) begin
              nerr++;
              $display("FAIL %s frame txd at tick %0d: actual=%0d expected=%0d", tg, bad_idx, bad_act, bad_exp);
            end
          end
        end
      end
    end
  end

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    while (!tx_rdy) @(negedge clk);
    wr = 1; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (len_q.size() != 0 || rem != 0 || !tx_emt) @(negedge clk);
    tk(2);
  endtask

  task automatic send(input logic [7:0] d, input string tag);
    expect_frame(d, 0, tag);
    put(d);
    wait_done();
  endtask

  task automatic do_enable();  @(negedge clk) tx_enable = 1;  @(negedge clk) tx_enable = 0;  endtask
  task automatic do_disable(); @(negedge clk) tx_disable = 1; @(negedge clk) tx_disable = 0; endtask
  task automatic do_set();     @(negedge clk) rts_set = 1;    @(negedge clk) rts_set = 0;    endtask
  task automatic do_clr();     @(negedge clk) rts_clr = 1;    @(negedge clk) rts_clr = 0;    endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R1", "txd after reset", txd, 1);
    chk(rts == 0, "R1", "rts after reset", rts, 0);
    chk(tx_rdy == 0, "R1", "tx_rdy after reset", tx_rdy, 0);
    chk(tx_emt == 1, "R1", "tx_emt after reset", tx_emt, 1);

    do_enable();
    chk(tx_rdy == 1, "R2", "tx_rdy after enable", tx_rdy, 1);
    chk(tx_emt == 1, "R2", "tx_emt after enable", tx_emt, 1);

    char_len = 3; par_en = 0; stop_code = 15; send(8'hA5, "R3 R4 8N code15");
    char_len = 2; par_en = 1; par_odd = 0; stop_code = 0; send(8'h5B, "R3 R4 7E code0");
    char_len = 1; par_odd = 1; stop_code = 7; send(8'h2C, "R3 R4 6O code7");
    char_len = 0; par_en = 0; stop_code = 0; send(8'h13, "R4 5N code0");
    stop_code = 15; send(8'h0E, "R4 5N code15");
    char_len = 3; par_en = 1; par_odd = 0; stop_code = 8; send(8'hFF, "R3 R4 8E code8");

    par_en = 0; stop_code = 4;
    expect_frame(8'h31, 0, "R6 back-to-back");
    expect_frame(8'hC2, 1, "R6 back-to-back");
    expect_frame(8'h7E, 1, "R6 back-to-back");
    put(8'h31); put(8'hC2); put(8'h7E);
    wait_done();

    cts_gate = 1; cts_n = 1; stop_code = 15;
    expect_frame(8'h96, 0, "R7 R8 cts gated");
    put(8'h96);
    tk(100);
    chk(txd == 1, "R7", "txd while cts negated", txd, 1);
    chk(tx_emt == 0, "R7", "tx_emt while held by cts", tx_emt, 0);
    @(negedge clk) cts_n = 0;
    @(negedge clk);
    while (txd) @(negedge clk);
    tk(40);
    cts_n = 1;
    wait_done();
    cts_gate = 0; cts_n = 1;
    send(8'h3C, "R8 gate off ignores cts_n");

    do_set();
    chk(rts == 1, "R11", "rts after set strobe", rts, 1);
    do_clr();
    chk(rts == 0, "R11", "rts after clear strobe", rts, 0);
    @(negedge clk) begin rts_set = 1; rts_clr = 1; end
    @(negedge clk) begin rts_set = 0; rts_clr = 0; end
    chk(rts == 1, "R11", "rts with set and clear together", rts, 1);
    auto_rts = 0;
    expect_frame(8'h55, 0, "R9 R11 drain auto off");
    put(8'h55);
    do_disable();
    chk(tx_rdy == 0, "R9", "tx_rdy during pending disable", tx_rdy, 0);
    wait_done();
    tk(40);
    chk(rts == 1, "R11", "rts after drain with auto off", rts, 1);
    chk(tx_rdy == 0, "R9", "tx_rdy after drain", tx_rdy, 0);
    do_enable();

    auto_rts = 1;
    do_disable();
    chk(tx_rdy == 0, "R11", "tx_rdy after disable in underrun", tx_rdy, 0);
    tk(40);
    chk(rts == 1, "R11", "rts after disable in underrun", rts, 1);
    do_enable();

    expect_frame(8'h81, 0, "R9 R10 held chars sent");
    expect_frame(8'h18, 1, "R9 R10 held chars sent");
    put(8'h81); put(8'h18);
    do_disable();
    chk(tx_rdy == 0, "R9", "tx_rdy after disable with data held", tx_rdy, 0);
    @(negedge clk);
    while (!tx_emt) @(negedge clk);
    tk(15);
    chk(rts == 1, "R10", "rts 15 ticks after drain", rts, 1);
    tk(1);
    chk(rts == 0, "R10", "rts 16 ticks after drain", rts, 0);
    chk(tx_rdy == 0, "R9", "tx_rdy once drained", tx_rdy, 0);
    @(negedge clk) begin wr = 1; wdata = 8'hE7; end
    @(negedge clk) wr = 0;
    chk(tx_emt == 1, "R2", "tx_emt after write while not ready", tx_emt, 1);
    do_enable();
    chk(tx_rdy == 1 && tx_emt == 1, "R2", "underrun after re-enable", int'(tx_rdy & tx_emt), 1);
    tk(60);
    chk(txd == 1, "R2", "line idle after ignored write", txd, 1);
    auto_rts = 0;

    x1_mode = 1; char_len = 3; par_en = 0; stop_code = 0;
    send(8'h6D, "R5 x1 one stop");
    stop_code = 8; send(8'hB2, "R5 x1 two stops");
    par_en = 1; par_odd = 1; send(8'h0F, "R5 x1 odd parity");

    chk(exp_q.size() == 0, "R3", "expected bits left over", exp_q.size(), 0);
    summary();
  end
endmodule